// File: doc/BRIEF.md
# Clustered Jacobi Iteration Solver Engine

This engine solves a small sparse linear system A·x = b by Jacobi iteration in signed Q8.24 fixed point. The matrix is block-diagonal: its rows are grouped into clusters of `ROWS` consecutive rows, and each cluster only couples unknowns of its own rows. One memory word holds a whole cluster, so every memory is `N_CLUST` words deep. A bank of `ROWS` identical row ALUs processes one cluster word per clock. Each ALU subtracts the off-diagonal products from the right-hand side and then multiplies by a stored reciprocal of the diagonal, so no divider is needed.

Before a run, software fills the inverse-diagonal, right-hand-side, coefficient and column-index stores through a simple preload port. A start pulse clears the solution store to zero and begins iterating. Each new value is compared with the value from the previous iteration. The run ends as converged when every unknown of an iteration moved by no more than the tolerance input. It ends as not converged when the iteration cap is reached. Results are read from the solution store through a combinational readout port.

Top module: `jacobi_engine`

## Requirements
- R1: Each unknown is updated as x_new = rnd(acc · invd), with acc = b − Σ rnd(coef_s · x_old[col_s]). Values are two's-complement Q8.24 in 32 bits. rnd(p) adds 2^23 to the 64-bit product and shifts it right arithmetically by 24. Sums wrap to 32 bits.
- R2: Each row has `NNZ` off-diagonal slots. A slot's column index selects a lane inside the same cluster. A slot whose coefficient is zero contributes nothing, whatever its index. Clusters never read each other's unknowns.
- R3: Reset and every accepted start set all unknowns to zero, so each run starts from x = 0. A repeated start with unchanged stores gives the same results and the same iteration count.
- R4: When every unknown of an iteration satisfies |x_new − x_old| ≤ tol (tol unsigned), `done` and `halt` go to 1 and `iter_cnt` equals the number of iterations run, including that last one. `done` holds until the next accepted start. `halt` is never 1 without `done`.
- R5: If `MAX_ITER` iterations complete without convergence, `done` = 1, `halt` = 0 and `iter_cnt` = `MAX_ITER`.
- R6: While a run is busy, `start` and preload writes are ignored: the run is not restarted and no store changes.
- R7: One cluster word is fetched per clock during the read phase of an iteration. An iteration takes `N_CLUST`+3 cycles, so `done` rises K·(`N_CLUST`+3) clock edges after the edge that accepts `start`, where K is the iteration count.
- R8: Preload encoding of `ld_kind`: 0 = inverse diagonal, 1 = right-hand side, 2 = coefficient, 3 = column index (low bits of `ld_data`). The target is addressed by `ld_clu`, `ld_lane` and `ld_slot`. `rd_data` shows the unknown at `rd_clu`/`rd_lane` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload write strobe |
| ld_kind | input | 2 | Preload target store (see R8) |
| ld_clu | input | CW | Cluster word address |
| ld_lane | input | LW | Row within the cluster |
| ld_slot | input | SW | Off-diagonal slot of the row |
| ld_data | input | W | Preload value |
| start | input | 1 | Start pulse, accepted when not busy |
| tol | input | W | Unsigned convergence tolerance in Q8.24 LSBs |
| done | output | 1 | Run finished |
| halt | output | 1 | Run finished by convergence |
| iter_cnt | output | ITW | Iterations completed in the current or last run |
| rd_clu | input | CW | Readout cluster address |
| rd_lane | input | LW | Readout row within the cluster |
| rd_data | output | W | Unknown at the readout address |

## Verification
A preload write or a second start pulse can arrive while the pipeline is writing results back to the solution store and the control unit is counting rows. The bench provokes this by pulsing both a few cycles into a converging run. It then judges the run by its final unknowns, iteration count and run length, which must equal those of the untouched system. The other coincidence is the end of an iteration landing on the iteration cap. An oscillating cluster provokes it, and the run must stop at exactly the cap with `halt` low.

// File: rtl/jac_pkg.sv
package jac_pkg;
   typedef enum logic [1:0] {
      LD_INVD = 2'd0,
      LD_RHS  = 2'd1,
      LD_COEF = 2'd2,
      LD_COL  = 2'd3
   } ld_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } eng_state_e;
endpackage

// File: rtl/jac_fx_mul.sv
module jac_fx_mul #(
   parameter int W          = 32,
   parameter int FRAC       = 24,
   parameter bit ROUND_NEAR = 1'b1
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] y
);
   localparam int PW = 2 * W;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] adj;

   always_comb prod = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};

   generate
      if (ROUND_NEAR) begin : g_round
         always_comb adj = prod + (PW'(1) <<< (FRAC - 1));
      end else begin : g_trunc
         always_comb adj = prod;
      end
   endgenerate

   always_comb y = W'(adj >>> FRAC);
endmodule

// File: rtl/jac_row_alu.sv
module jac_row_alu #(
   parameter int W          = 32,
   parameter int FRAC       = 24,
   parameter bit ROUND_NEAR = 1'b1,
   parameter int ROWS       = 2,
   parameter int NNZ        = 2,
   parameter int LW         = 1,
   parameter int LANE       = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ROWS*W-1:0]    x_word,
   input  logic [W-1:0]         b_in,
   input  logic [W-1:0]         invd_in,
   input  logic [NNZ*W-1:0]     coef_in,
   input  logic [NNZ*LW-1:0]    col_in,
   input  logic [W-1:0]         tol,
   output logic [W-1:0]         x_new,
   output logic                 ok
);
   logic signed [W-1:0] xsel [NNZ];
   logic signed [W-1:0] prod [NNZ];
   logic signed [W-1:0] sum;
   logic signed [W-1:0] acc_q, invd_q, xold_q;
   logic signed [W-1:0] nx;
   logic signed [W:0]   diff;
   logic        [W:0]   mag;

   always_comb begin
      for (int s = 0; s < NNZ; s++) begin
         int ci;
         ci = int'(col_in[s*LW +: LW]);
         xsel[s] = '0;
         if (ci < ROWS) xsel[s] = x_word[ci*W +: W];
      end
   end

   generate
      for (genvar s = 0; s < NNZ; s++) begin : g_slot
         jac_fx_mul #(.W(W), .FRAC(FRAC), .ROUND_NEAR(ROUND_NEAR)) u_mul (
            .a (coef_in[s*W +: W]),
            .b (xsel[s]),
            .y (prod[s])
         );
      end
   endgenerate

   always_comb begin
      sum = b_in;
      for (int s = 0; s < NNZ; s++) sum = sum - prod[s];
   end

   // stage A: accumulated right-hand side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         invd_q <= '0;
         xold_q <= '0;
      end else begin
         acc_q  <= sum;
         invd_q <= invd_in;
         xold_q <= x_word[LANE*W +: W];
      end
   end

   jac_fx_mul #(.W(W), .FRAC(FRAC), .ROUND_NEAR(ROUND_NEAR)) u_scale (
      .a (acc_q),
      .b (invd_q),
      .y (nx)
   );

   always_comb begin
      diff = {nx[W-1], nx} - {xold_q[W-1], xold_q};
      mag  = diff[W] ? $unsigned(-diff) : $unsigned(diff);
   end

   // stage B: new value and per-row convergence flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_new <= '0;
         ok    <= 1'b0;
      end else begin
         x_new <= nx;
         ok    <= (mag <= {1'b0, tol});
      end
   end
endmodule

// File: rtl/jac_ctrl.sv
module jac_ctrl
   import jac_pkg::*;
#(
   parameter int N_CLUST  = 4,
   parameter int MAX_ITER = 32,
   parameter int CW       = 2,
   parameter int ITW      = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           wb_v,
   input  logic           clu_ok,
   output logic           busy,
   output logic           start_go,
   output logic           rd_en,
   output logic [CW-1:0]  rd_ptr,
   output logic [CW-1:0]  wr_ptr,
   output logic           done,
   output logic           halt,
   output logic [ITW-1:0] iter_cnt
);
   localparam logic [CW-1:0]  LAST = CW'(N_CLUST - 1);
   localparam logic [ITW-1:0] CAP  = ITW'(MAX_ITER);

   eng_state_e state;
   logic       rd_phase;
   logic       all_ok;
   logic       last_wr;

   always_comb begin
      busy     = (state == ST_RUN);
      start_go = start && !busy;
      rd_en    = busy && rd_phase;
      last_wr  = wb_v && (wr_ptr == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         rd_phase <= 1'b0;
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         all_ok   <= 1'b1;
         done     <= 1'b0;
         halt     <= 1'b0;
         iter_cnt <= '0;
      end else if (start_go) begin
         state    <= ST_RUN;
         rd_phase <= 1'b1;
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         all_ok   <= 1'b1;
         done     <= 1'b0;
         halt     <= 1'b0;
         iter_cnt <= '0;
      end else if (busy) begin
         if (rd_en) begin
            if (rd_ptr == LAST) begin
               rd_ptr   <= '0;
               rd_phase <= 1'b0;
            end else begin
               rd_ptr <= rd_ptr + 1'b1;
            end
         end
         if (wb_v) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (last_wr) begin
            iter_cnt <= iter_cnt + 1'b1;
            if (all_ok && clu_ok) begin
               state <= ST_DONE;
               done  <= 1'b1;
               halt  <= 1'b1;
            end else if ((iter_cnt + 1'b1) == CAP) begin
               state <= ST_DONE;
               done  <= 1'b1;
               halt  <= 1'b0;
            end else begin
               rd_phase <= 1'b1;
               all_ok   <= 1'b1;
            end
         end else if (wb_v) begin
            all_ok <= all_ok && clu_ok;
         end
      end
   end
endmodule

// File: rtl/jacobi_engine.sv
module jacobi_engine
   import jac_pkg::*;
#(
   parameter int N_CLUST    = 4,
   parameter int ROWS       = 2,
   parameter int NNZ        = 2,
   parameter int W          = 32,
   parameter int FRAC       = 24,
   parameter int MAX_ITER   = 32,
   parameter bit ROUND_NEAR = 1'b1,
   localparam int CW  = (N_CLUST > 1) ? $clog2(N_CLUST) : 1,
   localparam int LW  = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int SW  = (NNZ > 1) ? $clog2(NNZ) : 1,
   localparam int ITW = $clog2(MAX_ITER + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_en,
   input  logic [1:0]     ld_kind,
   input  logic [CW-1:0]  ld_clu,
   input  logic [LW-1:0]  ld_lane,
   input  logic [SW-1:0]  ld_slot,
   input  logic [W-1:0]   ld_data,
   input  logic           start,
   input  logic [W-1:0]   tol,
   output logic           done,
   output logic           halt,
   output logic [ITW-1:0] iter_cnt,
   input  logic [CW-1:0]  rd_clu,
   input  logic [LW-1:0]  rd_lane,
   output logic [W-1:0]   rd_data
);
   localparam int XW = ROWS * W;
   localparam int KW = ROWS * NNZ * W;
   localparam int IW = ROWS * NNZ * LW;

   generate
      if (N_CLUST < 1 || ROWS < 1 || NNZ < 1 || MAX_ITER < 1) begin : g_bad_size
         $error("jacobi_engine: counts must be at least one");
      end
      if (FRAC < 1 || FRAC >= W) begin : g_bad_frac
         $error("jacobi_engine: FRAC must lie in 1..W-1");
      end
   endgenerate

   logic [N_CLUST-1:0][XW-1:0] invd_q, rhs_q, sol_q;
   logic [N_CLUST-1:0][KW-1:0] coef_q;
   logic [N_CLUST-1:0][IW-1:0] col_q;

   logic          busy, start_go, rd_en, wb_v;
   logic [CW-1:0] rd_ptr, wr_ptr;
   logic          f_v, a_v, b_v;
   logic [XW-1:0] f_x, f_b, f_invd, new_word;
   logic [KW-1:0] f_coef;
   logic [IW-1:0] f_col;
   logic [ROWS-1:0] ok_vec;
   logic          clu_ok;
   int            lane_base, coef_base, colf_base, rd_base;

   always_comb begin
      lane_base = int'(ld_lane) * W;
      coef_base = (int'(ld_lane) * NNZ + int'(ld_slot)) * W;
      colf_base = (int'(ld_lane) * NNZ + int'(ld_slot)) * LW;
      rd_base   = int'(rd_lane) * W;
      clu_ok    = &ok_vec;
      wb_v      = b_v;
   end

   // preload of the read-only stores, locked while a run is busy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         invd_q <= '0;
         rhs_q  <= '0;
         coef_q <= '0;
         col_q  <= '0;
      end else if (ld_en && !busy) begin
         case (ld_kind_e'(ld_kind))
            LD_INVD: invd_q[ld_clu][lane_base +: W] <= ld_data;
            LD_RHS:  rhs_q[ld_clu][lane_base +: W]  <= ld_data;
            LD_COEF: coef_q[ld_clu][coef_base +: W] <= ld_data;
            LD_COL:  col_q[ld_clu][colf_base +: LW] <= ld_data[LW-1:0];
            default: ;
         endcase
      end
   end

   // solution store: cleared on start, written back per cluster
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sol_q <= '0;
      else if (start_go) sol_q <= '0;
      else if (wb_v)     sol_q[wr_ptr] <= new_word;
   end

   // fetch stage: one cluster word from every store per clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_v    <= 1'b0;
         a_v    <= 1'b0;
         b_v    <= 1'b0;
         f_x    <= '0;
         f_b    <= '0;
         f_invd <= '0;
         f_coef <= '0;
         f_col  <= '0;
      end else begin
         f_v <= rd_en;
         a_v <= f_v;
         b_v <= a_v;
         if (rd_en) begin
            f_x    <= sol_q[rd_ptr];
            f_b    <= rhs_q[rd_ptr];
            f_invd <= invd_q[rd_ptr];
            f_coef <= coef_q[rd_ptr];
            f_col  <= col_q[rd_ptr];
         end
      end
   end

   generate
      for (genvar i = 0; i < ROWS; i++) begin : g_lane
         jac_row_alu #(
            .W(W), .FRAC(FRAC), .ROUND_NEAR(ROUND_NEAR),
            .ROWS(ROWS), .NNZ(NNZ), .LW(LW), .LANE(i)
         ) u_alu (
            .clk     (clk),
            .rst_n   (rst_n),
            .x_word  (f_x),
            .b_in    (f_b[i*W +: W]),
            .invd_in (f_invd[i*W +: W]),
            .coef_in (f_coef[i*NNZ*W +: NNZ*W]),
            .col_in  (f_col[i*NNZ*LW +: NNZ*LW]),
            .tol     (tol),
            .x_new   (new_word[i*W +: W]),
            .ok      (ok_vec[i])
         );
      end
   endgenerate

   jac_ctrl #(.N_CLUST(N_CLUST), .MAX_ITER(MAX_ITER), .CW(CW), .ITW(ITW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .wb_v     (wb_v),
      .clu_ok   (clu_ok),
      .busy     (busy),
      .start_go (start_go),
      .rd_en    (rd_en),
      .rd_ptr   (rd_ptr),
      .wr_ptr   (wr_ptr),
      .done     (done),
      .halt     (halt),
      .iter_cnt (iter_cnt)
   );

   always_comb rd_data = sol_q[rd_clu][rd_base +: W];
endmodule

// File: rtl/jac_engine_chk.sv
module jac_engine_chk #(
   parameter int N_CLUST  = 4,
   parameter int MAX_ITER = 32,
   parameter int CW       = 2,
   parameter int ITW      = 6,
   parameter int MW       = 256
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           done,
   input logic           halt,
   input logic [ITW-1:0] iter_cnt,
   input logic           busy,
   input logic           start_go,
   input logic           rd_en,
   input logic [CW-1:0]  rd_ptr,
   input logic [MW-1:0]  rhs_flat,
   input logic [MW-1:0]  sol_flat
);
   AST_HALT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> done);                                                       // R4
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);                                           // R4
   AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      iter_cnt <= ITW'(MAX_ITER));                                          // R5
   AST_STOP_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !halt) |-> (iter_cnt == ITW'(MAX_ITER)));                    // R5
   AST_RHS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rhs_flat));                                          // R6
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && iter_cnt != '0) |=> (iter_cnt != '0));              // R6
   AST_SOL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> (sol_flat == '0));                                       // R3
   AST_RD_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_ptr != CW'(N_CLUST - 1)) |=>
         (rd_en && rd_ptr == $past(rd_ptr) + 1'b1));                        // R7
endmodule

bind jacobi_engine jac_engine_chk #(
   .N_CLUST(N_CLUST), .MAX_ITER(MAX_ITER), .CW(CW), .ITW(ITW),
   .MW(N_CLUST * ROWS * W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .done     (done),
   .halt     (halt),
   .iter_cnt (iter_cnt),
   .busy     (busy),
   .start_go (start_go),
   .rd_en    (rd_en),
   .rd_ptr   (rd_ptr),
   .rhs_flat (rhs_q),
   .sol_flat (sol_q)
);

// File: tb/tb_jacobi_engine.sv
`timescale 1ns/1ps
module tb_jacobi_engine;
   localparam int NC   = 4;
   localparam int RW   = 2;
   localparam int NZ   = 2;
   localparam int MAXI = 32;

   typedef struct {
      int          kind;   // 0 value, 1 halt, 2 iter count, 3 run length
      int          c;
      int          r;
      logic [31:0] exp;
      string       rq;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [1:0]  ld_kind = '0;
   logic [1:0]  ld_clu = '0;
   logic [0:0]  ld_lane = '0;
   logic [0:0]  ld_slot = '0;
   logic [31:0] ld_data = '0;
   logic        start = 1'b0;
   logic [31:0] tol = '0;
   logic        done, halt;
   logic [5:0]  iter_cnt;
   logic [1:0]  rd_clu = '0;
   logic [0:0]  rd_lane = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int start_mark = 0;
   int runs_seen = 0;
   bit done_seen = 1'b0;
   item_t sb_q[$];

   int invd_m [NC][RW];
   int rhs_m  [NC][RW];
   int coef_m [NC][RW][NZ];
   int col_m  [NC][RW][NZ];

   jacobi_engine dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_kind(ld_kind),
      .ld_clu(ld_clu), .ld_lane(ld_lane), .ld_slot(ld_slot), .ld_data(ld_data),
      .start(start), .tol(tol), .done(done), .halt(halt), .iter_cnt(iter_cnt),
      .rd_clu(rd_clu), .rd_lane(rd_lane), .rd_data(rd_data)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic int fxm(input int a, input int b);
      longint p;
      p = longint'(a) * longint'(b) + (longint'(1) <<< 23);
      return int'(p >>> 24);
   endfunction

   // preload write through the port (R8), mirrored in the bench model
   task automatic put(input int k, input int c, input int r, input int s, input int d);
      case (k)
         0: invd_m[c][r] = d;
         1: rhs_m[c][r] = d;
         2: coef_m[c][r][s] = d;
         default: col_m[c][r][s] = d;
      endcase
      @(negedge clk);
      ld_en = 1'b1; ld_kind = 2'(k); ld_clu = 2'(c);
      ld_lane = 1'(r); ld_slot = 1'(s); ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic load_row_a(input int c, input int r);
      int b;
      b = ((c * 2 + r + 1) <<< 24) + c * 3 + r;
      if (c == 3) b = -b;
      put(0, c, r, 0, 32'h0040_0000);           // 0.25
      put(1, c, r, 0, b);
      put(2, c, r, 0, 32'hFF00_0000);           // -1.0
      put(3, c, r, 0, 1 - r);
      put(2, c, r, 1, (c == 2) ? 32'h0080_0000 : 0);
      put(3, c, r, 1, 1 - r);                   // R2: index aimed at neighbour, zero coef
   endtask

   // driver: model the run and push expectations into the scoreboard
   task automatic run_case(input logic [31:0] tolv, input bit poke, input string rq);
      int x  [NC][RW];
      int xn [NC][RW];
      int k;
      bit conv;
      int target;
      for (int c = 0; c < NC; c++)
         for (int r = 0; r < RW; r++) x[c][r] = 0;
      k = 0;
      do begin
         conv = 1'b1;
         for (int c = 0; c < NC; c++) begin
            for (int r = 0; r < RW; r++) begin
               int acc;
               longint d;
               acc = rhs_m[c][r];
               for (int s = 0; s < NZ; s++)
                  acc = acc - fxm(coef_m[c][r][s], x[c][col_m[c][r][s]]);
               xn[c][r] = fxm(acc, invd_m[c][r]);
               d = longint'(xn[c][r]) - longint'(x[c][r]);
               if (d < 0) d = -d;
               if (d > longint'({32'b0, tolv})) conv = 1'b0;
            end
         end
         x = xn;
         k++;
      end while (!conv && k < MAXI);

      sb_q.push_back('{1, 0, 0, 32'(conv), conv ? "R4" : "R5"});
      sb_q.push_back('{2, 0, 0, 32'(k), conv ? "R4" : "R5"});
      sb_q.push_back('{3, 0, 0, 32'(k * (NC + 3)), "R7"});
      for (int c = 0; c < NC; c++)
         for (int r = 0; r < RW; r++)
            sb_q.push_back('{0, c, r, x[c][r], rq});

      target = runs_seen + 1;
      @(negedge clk);
      tol = tolv;
      start_mark = cyc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;                          // R6: ignored restart
         ld_en = 1'b1; ld_kind = 2'd1; ld_clu = 2'd1; ld_lane = 1'b0;
         ld_data = 32'h6300_0000;               // R6: ignored rhs write
         @(negedge clk);
         start = 1'b0;
         ld_en = 1'b0;
      end
      wait (runs_seen == target);
   endtask

   // monitor: on each completed run, pop and compare the expectations
   initial begin
      forever begin
         @(negedge clk);
         if (done && !done_seen) begin
            done_seen = 1'b1;
            while (sb_q.size() > 0) begin
               item_t it;
               it = sb_q.pop_front();
               case (it.kind)
                  1: chk(it.rq, "halt", 32'(halt), it.exp);
                  2: chk(it.rq, "iter_cnt", 32'(iter_cnt), it.exp);
                  3: chk(it.rq, "run length", 32'(cyc - start_mark - 1), it.exp);
                  default: begin
                     rd_clu = 2'(it.c);
                     rd_lane = 1'(it.r);
                     #0.1;
                     chk(it.rq, $sformatf("x[%0d][%0d]", it.c, it.r), rd_data, it.exp);
                  end
               endcase
            end
            runs_seen++;
         end else if (!done) begin
            done_seen = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++)
         for (int r = 0; r < RW; r++) begin
            invd_m[c][r] = 0; rhs_m[c][r] = 0;
            for (int s = 0; s < NZ; s++) begin
               coef_m[c][r][s] = 0; col_m[c][r][s] = 0;
            end
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R4", "done after reset", 32'(done), 0);
      chk("R4", "halt after reset", 32'(halt), 0);
      chk("R4", "iter_cnt after reset", 32'(iter_cnt), 0);
      rd_clu = 2'd2; rd_lane = 1'b1; #0.1;
      chk("R3", "x after reset", rd_data, 0);

      for (int c = 0; c < NC; c++)
         for (int r = 0; r < RW; r++) load_row_a(c, r);

      // R1: wide tolerance stops after one update from zero
      run_case(32'h7FFF_FFFF, 1'b0, "R1");
      // R2/R4: tight tolerance, about 1e-6 in Q8.24
      run_case(32'd17, 1'b0, "R2");
      // R5: cluster 0 oscillates between 0 and 1
      for (int r = 0; r < RW; r++) begin
         put(0, 0, r, 0, 32'h0100_0000);
         put(1, 0, r, 0, 32'h0100_0000);
         put(2, 0, r, 0, 32'h0100_0000);
      end
      run_case(32'd17, 1'b0, "R5");
      // R6: restart and preload during a run are ignored
      for (int r = 0; r < RW; r++) load_row_a(0, r);
      run_case(32'd17, 1'b1, "R6");
      // R3: a repeated start begins again from zero
      run_case(32'd17, 1'b0, "R3");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule